// File: doc/BRIEF.md
# Pin-State Serial Reporter

This block watches a small group of input pins and streams their state, over and over, on one serial output line. It is meant for board bring-up. A host that can see only that one line, and that controls when bits move, can still read back every pin the block observes. It needs no extra framing or strobe wires.

Every bit of output moves on a one-cycle step strobe in the system clock domain. The strobe would normally come from a synchronised external shift clock. Each frame has three parts, in this order:

- a run of zeros;
- a single one;
- the pin values, lowest pin first.

No run of zeros in the pin section can be as long as the leading run. A receiver can therefore lock onto the frame from the data alone. The pins are latched into a holding register on the step that sends the one. A frame therefore always reports a single moment in time.

Top module: `pin_reporter`

## Requirements
- R1: While `rst_ni` is low, `sdo_o` is 0 and the frame position returns to the start of the zero run.
- R2: The first 20 steps of every frame drive `sdo_o` to 0.
- R3: Step 21 of every frame drives `sdo_o` to 1. This is the marker bit.
- R4: Steps 22 to 31 drive the held pin values in order: pin 0 first, pin 9 last.
- R5: `pins_i` is latched on the marker step only. Pin changes at any other step have no effect on the bits of the frame that is being sent.
- R6: A frame is 31 steps long. The next frame's zero run starts on the step after pin 9, with no gap.
- R7: On a cycle without a step strobe, `sdo_o` keeps its value.
- R8: After reset is released, the first step sends the first zero of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_en_i | input | 1 | One-cycle strobe; each high cycle advances the output by one bit |
| pins_i | input | 10 | Pin states to report |
| sdo_o | output | 1 | Serial frame output, registered |

## Verification
`sdo_o` is registered, so the bit for a step appears right after the clock edge where `shift_en_i` is high. The bench compares it a quarter period after that same edge. Inputs change only on the falling edge. The pin latch happens on the marker edge, so pin 0 is due one step after the marker. The behavioural model and the stream decoder both record `pins_i` at that edge. Pin changes made later in the frame are then shown to leave the decoded bits untouched. When no strobe is present, the compare at the next edge expects the previous bit. A reset asserted mid-frame is followed by a check that the next step starts a fresh zero run.

// File: rtl/pinrep_pkg.sv
package pinrep_pkg;
  typedef enum logic [1:0] {
    PH_PRE  = 2'd0,
    PH_MARK = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/pinrep_seq.sv
module pinrep_seq
  import pinrep_pkg::*;
#(
  parameter int PRE_LEN = 20,
  parameter int PIN_W   = 10,
  parameter int POS_W   = 5,
  parameter int IDX_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [POS_W-1:0] pos_o,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int FRAME_LEN = PRE_LEN + 1 + PIN_W;
  localparam logic [POS_W-1:0] LAST_POS   = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] MARK_POS   = POS_W'(PRE_LEN);
  localparam logic [POS_W-1:0] DATA_START = POS_W'(PRE_LEN + 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (step_i) pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  end

  always_comb begin
    if (pos_q < MARK_POS)       phase_o = PH_PRE;
    else if (pos_q == MARK_POS) phase_o = PH_MARK;
    else                        phase_o = PH_DATA;
  end

  assign diff  = pos_q - DATA_START;
  assign idx_o = diff[IDX_W-1:0];
  assign pos_o = pos_q;
endmodule

// File: rtl/pinrep_hold.sv
module pinrep_hold #(
  parameter int PIN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PIN_W-1:0] pins_i,
  output logic [PIN_W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_o <= '0;
    else if (load_i) hold_o <= pins_i;
  end
endmodule

// File: rtl/pinrep_tx.sv
module pinrep_tx
  import pinrep_pkg::*;
#(
  parameter int PIN_W = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  phase_e           phase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PIN_W-1:0] hold_i,
  output logic             sdo_o
);
  logic data_bit;
  logic next_bit;

  // out-of-range index cannot occur in PH_DATA; default 0 keeps it safe
  always_comb begin
    data_bit = 1'b0;
    for (int j = 0; j < PIN_W; j++) begin
      if (idx_i == IDX_W'(j)) data_bit = hold_i[j];
    end
  end

  always_comb begin
    unique case (phase_i)
      PH_PRE:  next_bit = 1'b0;
      PH_MARK: next_bit = 1'b1;
      PH_DATA: next_bit = data_bit;
      default: next_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sdo_o <= 1'b0;
    else if (step_i) sdo_o <= next_bit;
  end
endmodule

// File: rtl/pin_reporter.sv
module pin_reporter
  import pinrep_pkg::*;
#(
  parameter int PRE_LEN = 20,
  parameter int PIN_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic [PIN_W-1:0] pins_i,
  output logic             sdo_o
);
  localparam int FRAME_LEN = PRE_LEN + 1 + PIN_W;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int IDX_W     = (PIN_W > 1) ? $clog2(PIN_W) : 1;

  logic [POS_W-1:0] pos_q;
  phase_e           phase;
  logic [IDX_W-1:0] data_idx;
  logic [PIN_W-1:0] hold_q;
  logic             cap_en;

  pinrep_seq #(
    .PRE_LEN(PRE_LEN), .PIN_W(PIN_W), .POS_W(POS_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (shift_en_i),
    .pos_o   (pos_q),
    .phase_o (phase),
    .idx_o   (data_idx)
  );

  // latch on the marker step so pin 0 is valid for the next step
  assign cap_en = shift_en_i && (phase == PH_MARK);

  pinrep_hold #(.PIN_W(PIN_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cap_en),
    .pins_i (pins_i),
    .hold_o (hold_q)
  );

  pinrep_tx #(.PIN_W(PIN_W), .IDX_W(IDX_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (shift_en_i),
    .phase_i (phase),
    .idx_i   (data_idx),
    .hold_i  (hold_q),
    .sdo_o   (sdo_o)
  );
endmodule

// File: rtl/pin_reporter_chk.sv
module pin_reporter_chk #(
  parameter int PRE_LEN = 20,
  parameter int PIN_W   = 10,
  parameter int POS_W   = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_en_i,
  input logic [PIN_W-1:0] pins_i,
  input logic             sdo_o,
  input logic [POS_W-1:0] pos_q,
  input logic [PIN_W-1:0] hold_q
);
  localparam int FRAME_LEN = PRE_LEN + 1 + PIN_W;

  logic exp_bit;
  always_comb begin
    exp_bit = 1'b0;
    for (int j = 0; j < PIN_W; j++) begin
      if (int'(pos_q) == PRE_LEN + 1 + j) exp_bit = hold_q[j];
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_low: assert (!sdo_o && pos_q == '0);
    end
  end

  a_r2_preamble_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i && int'(pos_q) < PRE_LEN |=> !sdo_o);

  a_r3_marker_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i && int'(pos_q) == PRE_LEN |=> sdo_o);

  a_r4_pin_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i && int'(pos_q) > PRE_LEN |=> sdo_o == $past(exp_bit));

  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i && int'(pos_q) == PRE_LEN |=> hold_q == $past(pins_i));

  a_r5_hold_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_en_i && int'(pos_q) == PRE_LEN) |=> $stable(hold_q));

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i && int'(pos_q) == FRAME_LEN - 1 |=> pos_q == '0);

  a_r7_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(sdo_o) && $stable(pos_q));
endmodule

bind pin_reporter pin_reporter_chk #(
  .PRE_LEN(PRE_LEN), .PIN_W(PIN_W), .POS_W(POS_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shift_en_i (shift_en_i),
  .pins_i     (pins_i),
  .sdo_o      (sdo_o),
  .pos_q      (pos_q),
  .hold_q     (hold_q)
);

// File: tb/tb_pin_reporter.sv
module tb_pin_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 20;
  localparam int NP  = 10;
  localparam int FL  = PRE + 1 + NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          sdo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pin_reporter #(.PRE_LEN(PRE), .PIN_W(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .shift_en_i(en), .pins_i(pins), .sdo_o(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int          m_pos = 0;
  logic        m_exp = 1'b0;
  logic [NP-1:0] m_cap = '0;
  string       m_tag = "R1";
  bit          m_first = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_exp = 1'b0; m_cap = '0; m_tag = "R1"; m_first = 1'b1;
    end else if (en) begin
      if (m_pos < PRE) begin
        m_exp = 1'b0; m_tag = m_first ? "R8" : "R2";
      end else if (m_pos == PRE) begin
        m_exp = 1'b1; m_cap = pins; m_tag = "R3";
      end else begin
        m_exp = m_cap[m_pos-PRE-1]; m_tag = "R4";
      end
      m_first = 1'b0;
      m_pos = (m_pos + 1) % FL;
    end else if (rst_n) begin
      m_tag = "R7";
    end
  end

  // stream decoder
  int          zrun = 0;
  int          since_mark = -1;
  int          nbits = 0;
  logic [NP-1:0] dec_pins = '0;
  logic [NP-1:0] got = '0;
  bit          in_data = 0;

  always @(posedge clk) begin
    logic step;
    step = en && rst_n;
    #(CLK_PERIOD/4);
    checks++;
    if (sdo !== m_exp) begin
      errors++;
      $display("FAIL %s: sdo=%b expected %b at %0t", m_tag, sdo, m_exp, $time);
    end
    if (!rst_n) begin
      zrun = 0; since_mark = -1; in_data = 0;
    end else if (step) begin
      if (since_mark >= 0) since_mark++;
      if (in_data) begin
        got[nbits] = sdo;
        nbits++;
        if (nbits == NP) begin
          in_data = 0;
          checks++;
          if (got !== dec_pins) begin
            errors++;
            $display("FAIL R5: decoded pins=%h expected %h", got, dec_pins);
          end
        end
      end else if (sdo) begin
        checks++;
        if (zrun != PRE) begin
          errors++;
          $display("FAIL R2: zero run=%0d expected %0d", zrun, PRE);
        end
        if (since_mark > 0) begin
          checks++;
          if (since_mark != FL) begin
            errors++;
            $display("FAIL R6: frame length=%0d expected %0d", since_mark, FL);
          end
        end
        since_mark = 0;
        dec_pins = pins;
        in_data = 1; nbits = 0; zrun = 0;
      end else begin
        zrun++;
      end
    end
  end

  task automatic tick(input bit e, input logic [NP-1:0] p);
    @(negedge clk);
    en = e;
    pins = p;
  endtask

  initial begin
    // R1: strobes during reset must not move the output
    for (int i = 0; i < 4; i++) tick(1'b1, NP'(i * 37));
    @(negedge clk);
    rst_n = 1'b1;
    // continuous strobe, pins changing often (R5, R6)
    for (int i = 0; i < 3 * FL + 5; i++) tick(1'b1, NP'(i * 7 + 3));
    // walking one patterns with gaps (R4, R7)
    for (int i = 0; i < 4 * FL * 2; i++)
      tick((i % 3) != 0, NP'(1) << ((i / (2 * FL)) % NP));
    // all ones then all zeros
    for (int i = 0; i < 2 * FL; i++) tick(1'b1, '1);
    for (int i = 0; i < 2 * FL; i++) tick(1'b1, '0);
    for (int i = 0; i < 2 * FL; i++) tick(i % 2 == 0, NP'(10'h2AA));
    // reset mid-frame, then fresh frame (R8)
    for (int i = 0; i < 7; i++) tick(1'b1, NP'(10'h155));
    @(negedge clk);
    rst_n = 1'b0;
    tick(1'b1, NP'(10'h0F0));
    tick(1'b1, NP'(10'h0F0));
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3 * FL; i++) tick(1'b1, NP'(10'h0F0 ^ i));
    tick(1'b0, '0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule